// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is an 8-bit control and status register inside a small microcontroller. It holds the enable bits for two timer counters and a request flag for each timer. A timer's request flag is set when that timer wraps past its all-ones count. The block also watches two active-low external interrupt pins. For each pin, a type bit selects one of two detection modes: a falling edge, or a low level. The pin's request flag is set when the selected condition is seen.

Software reads and writes the whole register over a simple special-function-register bus. Read data is always present on the read port, and a write takes effect on the next clock edge. The interrupt controller sees the four request flags and returns an acknowledge strobe when it services a source.

An acknowledge always clears a timer flag. An acknowledge clears an external flag only when that pin is in edge mode. If a hardware set and a software write to the same flag fall in one clock, the hardware set wins.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset, all eight register bits read 0 and every run and flag output is 0.
- R2: A write loads all eight bits with this software-visible layout: bit 7 timer-1 flag, bit 6 timer-1 run, bit 5 timer-0 flag, bit 4 timer-0 run, bit 3 ext-1 flag, bit 2 ext-1 type, bit 1 ext-0 flag, bit 0 ext-0 type. The read port shows the current register value.
- R3: The timer run outputs equal register bits 6 and 4 at all times. A written value appears on them one clock after the write.
- R4: A timer overflow pulse sets that timer's flag on the next clock edge. A timer acknowledge clears it, unless an overflow arrives in the same cycle, in which case the flag stays set.
- R5: Edge mode (type bit = 1) works as follows. A high-to-low transition on the pin sets the request flag on the third clock edge after the pin changes. A pin that stays low sets the flag only once.
- R6: Level mode (type bit = 0) works as follows. A low pin sets the request flag on the third clock edge after the pin falls, and sets it again on every cycle while the pin stays low. After the pin returns high, the flag stays set until software or an edge-mode acknowledge clears it.
- R7: An external acknowledge clears the request flag only when its type bit is 1. In level mode, the acknowledge leaves the flag unchanged.
- R8: Each flag bit follows a fixed priority: a hardware set comes first, then a software write, then an acknowledge clear.
- R9: The four flag outputs equal register bits 7, 5, 3 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sfrWr | input | 1 | Register write strobe |
| sfrWdata | input | 8 | Register write data |
| sfrRdata | output | 8 | Register read data |
| tmrOvf0 | input | 1 | Timer 0 wrap pulse |
| tmrOvf1 | input | 1 | Timer 1 wrap pulse |
| tmrAck0 | input | 1 | Timer 0 interrupt acknowledge |
| tmrAck1 | input | 1 | Timer 1 interrupt acknowledge |
| extAck0 | input | 1 | External 0 interrupt acknowledge |
| extAck1 | input | 1 | External 1 interrupt acknowledge |
| extPinN0 | input | 1 | External interrupt pin 0, active low |
| extPinN1 | input | 1 | External interrupt pin 1, active low |
| tmrRun0 | output | 1 | Timer 0 run enable |
| tmrRun1 | output | 1 | Timer 1 run enable |
| tmrFlag0 | output | 1 | Timer 0 request flag |
| tmrFlag1 | output | 1 | Timer 1 request flag |
| extFlag0 | output | 1 | External 0 request flag |
| extFlag1 | output | 1 | External 1 request flag |

## Verification
The bench builds the block with its default synchronizer depth of two flops. With that depth, a pin change reaches its request flag on exactly the third clock edge. The bench checks that flag on the second edge and again on the third, so an extra or missing pipeline stage is caught. Same-cycle collisions of overflow, write and acknowledge are driven directly, so the bench checks the set, write and clear priority one flag bit at a time.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_CH   = 2;
  // bit positions decoded by software
  localparam int POS_TFLAG1 = 7;
  localparam int POS_TRUN1  = 6;
  localparam int POS_TFLAG0 = 5;
  localparam int POS_TRUN0  = 4;
  localparam int POS_EFLAG1 = 3;
  localparam int POS_ETYPE1 = 2;
  localparam int POS_EFLAG0 = 1;
  localparam int POS_ETYPE0 = 0;

  typedef struct packed {
    logic [NUM_CH-1:0] tmrSet;
    logic [NUM_CH-1:0] tmrClr;
    logic [NUM_CH-1:0] extSet;
    logic [NUM_CH-1:0] extClr;
  } ctlStrobes_t;
endpackage

// File: rtl/tic_ctrl.sv
module tic_ctrl
  import tic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pinN,
  input  logic [NUM_CH-1:0] tmrOvf,
  input  logic [NUM_CH-1:0] tmrAck,
  input  logic [NUM_CH-1:0] extAck,
  input  logic [NUM_CH-1:0] extType,
  output ctlStrobes_t       strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_CH-1:0] syncPin;
  logic [NUM_CH-1:0] prevPin;
  logic [NUM_CH-1:0] fallSeen;
  logic [NUM_CH-1:0] lowSeen;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain       <= '1;
        prevPin[ch] <= 1'b1;
      end else begin
        chain       <= {chain[LAST-1:0], pinN[ch]};
        prevPin[ch] <= chain[LAST];
      end
    end

    assign syncPin[ch]  = chain[LAST];
    assign fallSeen[ch] = prevPin[ch] & ~syncPin[ch];
    assign lowSeen[ch]  = ~syncPin[ch];
  end

  always_comb begin
    strobes.tmrSet = tmrOvf;
    strobes.tmrClr = tmrAck;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      strobes.extSet[ch] = extType[ch] ? fallSeen[ch] : lowSeen[ch];
      strobes.extClr[ch] = extAck[ch] & extType[ch];
    end
  end
endmodule

// File: rtl/tic_regs.sv
module tic_regs
  import tic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  ctlStrobes_t      strobes,
  output logic [REG_W-1:0] regQ
);
  localparam int TFLAG_POS [NUM_CH] = '{POS_TFLAG0, POS_TFLAG1};
  localparam int TRUN_POS  [NUM_CH] = '{POS_TRUN0,  POS_TRUN1};
  localparam int EFLAG_POS [NUM_CH] = '{POS_EFLAG0, POS_EFLAG1};
  localparam int ETYPE_POS [NUM_CH] = '{POS_ETYPE0, POS_ETYPE1};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bits
    // plain control bits: software only
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[TRUN_POS[ch]]  <= 1'b0;
        regQ[ETYPE_POS[ch]] <= 1'b0;
      end else if (wr) begin
        regQ[TRUN_POS[ch]]  <= wdata[TRUN_POS[ch]];
        regQ[ETYPE_POS[ch]] <= wdata[ETYPE_POS[ch]];
      end
    end

    // flags: hardware set, then write, then acknowledge clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[TFLAG_POS[ch]] <= 1'b0;
      end else if (strobes.tmrSet[ch]) begin
        regQ[TFLAG_POS[ch]] <= 1'b1;
      end else if (wr) begin
        regQ[TFLAG_POS[ch]] <= wdata[TFLAG_POS[ch]];
      end else if (strobes.tmrClr[ch]) begin
        regQ[TFLAG_POS[ch]] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[EFLAG_POS[ch]] <= 1'b0;
      end else if (strobes.extSet[ch]) begin
        regQ[EFLAG_POS[ch]] <= 1'b1;
      end else if (wr) begin
        regQ[EFLAG_POS[ch]] <= wdata[EFLAG_POS[ch]];
      end else if (strobes.extClr[ch]) begin
        regQ[EFLAG_POS[ch]] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
  import tic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sfrWr,
  input  logic [7:0] sfrWdata,
  output logic [7:0] sfrRdata,
  input  logic       tmrOvf0,
  input  logic       tmrOvf1,
  input  logic       tmrAck0,
  input  logic       tmrAck1,
  input  logic       extAck0,
  input  logic       extAck1,
  input  logic       extPinN0,
  input  logic       extPinN1,
  output logic       tmrRun0,
  output logic       tmrRun1,
  output logic       tmrFlag0,
  output logic       tmrFlag1,
  output logic       extFlag0,
  output logic       extFlag1
);
  ctlStrobes_t      strobes;
  logic [REG_W-1:0] regQ;

  tic_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pinN    ({extPinN1, extPinN0}),
    .tmrOvf  ({tmrOvf1, tmrOvf0}),
    .tmrAck  ({tmrAck1, tmrAck0}),
    .extAck  ({extAck1, extAck0}),
    .extType ({regQ[POS_ETYPE1], regQ[POS_ETYPE0]}),
    .strobes (strobes)
  );

  tic_regs i_regs (
    .clk     (clk),
    .rstN    (rstN),
    .wr      (sfrWr),
    .wdata   (sfrWdata),
    .strobes (strobes),
    .regQ    (regQ)
  );

  assign sfrRdata = regQ;
  assign tmrRun0  = regQ[POS_TRUN0];
  assign tmrRun1  = regQ[POS_TRUN1];
  assign tmrFlag0 = regQ[POS_TFLAG0];
  assign tmrFlag1 = regQ[POS_TFLAG1];
  assign extFlag0 = regQ[POS_EFLAG0];
  assign extFlag1 = regQ[POS_EFLAG1];
endmodule

// File: rtl/tmr_irq_ctl_chk.sv
module tmr_irq_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sfrWr,
  input logic [7:0] sfrWdata,
  input logic [7:0] sfrRdata,
  input logic       tmrOvf0,
  input logic       tmrOvf1,
  input logic       tmrAck0,
  input logic       tmrAck1,
  input logic       extAck0,
  input logic       extAck1,
  input logic       extPinN0,
  input logic       extPinN1,
  input logic       tmrRun0,
  input logic       tmrRun1,
  input logic       tmrFlag0,
  input logic       tmrFlag1,
  input logic       extFlag0,
  input logic       extFlag1
);
  AST_TMR0_SET: assert property (@(posedge clk) disable iff (!rstN) tmrOvf0 |=> tmrFlag0); // R4
  AST_TMR1_SET: assert property (@(posedge clk) disable iff (!rstN) tmrOvf1 |=> tmrFlag1); // R4
  AST_TMR0_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (tmrAck0 && !tmrOvf0 && !sfrWr) |=> !tmrFlag0); // R4
  AST_RUN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    sfrWr |=> (tmrRun0 == $past(sfrWdata[4]) && tmrRun1 == $past(sfrWdata[6]))); // R3
  AST_LVL_ACK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (extAck0 && !sfrRdata[0] && extFlag0 && !sfrWr) |=> extFlag0); // R7
  AST_WR_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (sfrWr && tmrOvf1 && !sfrWdata[7]) |=> tmrFlag1); // R8
  AST_FLAG1_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sfrWr && !tmrOvf1 && !tmrAck1) |=> $stable(tmrFlag1)); // R4
endmodule

bind tmr_irq_ctl tmr_irq_ctl_chk i_chk (.*);

// File: tb/test_tmr_irq_ctl.sv
`timescale 1ns/1ps
module test_tmr_irq_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sfrWr = 1'b0;
  logic [7:0] sfrWdata = 8'h00;
  logic [7:0] sfrRdata;
  logic       tmrOvf0 = 0, tmrOvf1 = 0, tmrAck0 = 0, tmrAck1 = 0;
  logic       extAck0 = 0, extAck1 = 0, extPinN0 = 1, extPinN1 = 1;
  logic       tmrRun0, tmrRun1, tmrFlag0, tmrFlag1, extFlag0, extFlag1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tmr_irq_ctl i_tmr_irq_ctl (.*);

  // {pad7, wr, wdata8, ovf2, tack2, eack2, pad2, exp8}
  localparam int NV = 15;
  localparam logic [31:0] VEC [NV] = '{
    {7'd0,1'b1,8'h55,2'b00,2'b00,2'b00,2'b00,8'h55}, // R2 write
    {7'd0,1'b1,8'hAA,2'b00,2'b00,2'b00,2'b00,8'hAA}, // R2 write
    {7'd0,1'b0,8'h00,2'b00,2'b11,2'b00,2'b00,8'h0A}, // R4 ack clear
    {7'd0,1'b0,8'h00,2'b00,2'b00,2'b11,2'b00,8'h0A}, // R7 level ack no clear
    {7'd0,1'b1,8'h05,2'b00,2'b00,2'b00,2'b00,8'h05},
    {7'd0,1'b1,8'h0F,2'b00,2'b00,2'b00,2'b00,8'h0F},
    {7'd0,1'b0,8'h00,2'b00,2'b00,2'b01,2'b00,8'h0D}, // R7 edge ack0
    {7'd0,1'b0,8'h00,2'b00,2'b00,2'b10,2'b00,8'h05}, // R7 edge ack1
    {7'd0,1'b0,8'h00,2'b01,2'b00,2'b00,2'b00,8'h25}, // R4 set
    {7'd0,1'b1,8'h05,2'b10,2'b00,2'b00,2'b00,8'h85}, // R8 set beats write
    {7'd0,1'b0,8'h00,2'b01,2'b01,2'b00,2'b00,8'hA5}, // R4 set beats ack
    {7'd0,1'b1,8'hFF,2'b00,2'b10,2'b00,2'b00,8'hFF}, // R8 write beats ack
    {7'd0,1'b0,8'h00,2'b00,2'b11,2'b00,2'b00,8'h5F}, // R4
    {7'd0,1'b0,8'h00,2'b00,2'b00,2'b11,2'b00,8'h55}, // R7
    {7'd0,1'b1,8'h00,2'b00,2'b00,2'b00,2'b00,8'h00}  // R2
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkOuts(input string req, input logic [7:0] exp);
    check(req, {24'd0, sfrRdata}, {24'd0, exp});
    check("R3", {31'd0, tmrRun1}, {31'd0, exp[6]});
    check("R3", {31'd0, tmrRun0}, {31'd0, exp[4]});
    check("R9", {28'd0, tmrFlag1, tmrFlag0, extFlag1, extFlag0},
          {28'd0, exp[7], exp[5], exp[3], exp[1]});
  endtask

  task automatic writeReg(input logic [7:0] d);
    sfrWr = 1'b1; sfrWdata = d;
    tick();
    sfrWr = 1'b0; sfrWdata = 8'h00;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOuts("R1", 8'h00);
    rstN = 1'b1;
    tick();
    checkOuts("R1", 8'h00);

    for (int i = 0; i < NV; i++) begin
      sfrWr    = VEC[i][24];
      sfrWdata = VEC[i][23:16];
      {tmrOvf1, tmrOvf0} = VEC[i][15:14];
      {tmrAck1, tmrAck0} = VEC[i][13:12];
      {extAck1, extAck0} = VEC[i][11:10];
      tick();
      sfrWr = 0; sfrWdata = 0;
      {tmrOvf1, tmrOvf0, tmrAck1, tmrAck0, extAck1, extAck0} = '0;
      checkOuts("R2", VEC[i][7:0]);
    end

    // R5: edge mode on pin 0, three-edge latency
    writeReg(8'h01);
    extPinN0 = 1'b0;
    tick(); tick();
    check("R5 early", {31'd0, extFlag0}, 32'd0);
    tick();
    check("R5 set", {31'd0, extFlag0}, 32'd1);
    writeReg(8'h01);
    tick(); tick();
    check("R5 once", {31'd0, extFlag0}, 32'd0);
    extPinN0 = 1'b1;
    tick(); tick(); tick();

    // R6: level mode on pin 1
    writeReg(8'h00);
    extPinN1 = 1'b0;
    tick(); tick();
    check("R6 early", {31'd0, extFlag1}, 32'd0);
    tick();
    check("R6 set", {31'd0, extFlag1}, 32'd1);
    writeReg(8'h00);
    check("R8 set beats write", {31'd0, extFlag1}, 32'd1);
    extAck1 = 1'b1;
    tick();
    extAck1 = 1'b0;
    check("R7 level ack", {31'd0, extFlag1}, 32'd1);
    extPinN1 = 1'b1;
    tick(); tick(); tick();
    check("R6 latched", {31'd0, extFlag1}, 32'd1);
    writeReg(8'h00);
    check("R6 cleared", {31'd0, extFlag1}, 32'd0);

    // R1: reset mid-run
    writeReg(8'hFF);
    rstN = 1'b0;
    #1;
    checkOuts("R1", 8'h00);
    tick();
    rstN = 1'b1;
    tick();
    checkOuts("R1", 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule